// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block sits in the transmit path of a T1 framer. It rewrites the least significant bit of every channel byte in the signaling frames of a serial PCM stream. It runs on the transmit bit clock and takes one PCM bit per cycle. A frame sync pulse marks the framing bit, and a multiframe sync pulse marks the framing bit of frame 1. Three multiframe formats are supported: the 12-frame superframe with A/B bits, the 24-frame extended superframe with A/B/C/D bits, and the extended superframe with 4-state signaling, in which A/B is sent twice.

Each of the 24 channels selects its own signaling source. The source can be the incoming PCM (the byte is left untouched), a static per-channel signaling nibble presented on a wide input, or a serial signaling bus that runs beside the PCM on the same bit clock. Bits taken from the serial bus are collected into a per-channel holding register. They take effect only at the next multiframe sync, so a multiframe never carries a blend of old and new signaling.

Top module: `t1_rbs_inserter`

## Requirements
- R1: `ser_out` is `ser_in` delayed by exactly one clock whenever the bit is not the last bit of a channel byte in a signaling frame.
- R2: A cycle with `fsync` or `msync` high carries the framing bit, and that bit passes through unchanged. The next 192 bits are channels 0 to 23, 8 bits each, with the LSB last.
- R3: With `mode`=0 (superframe) the multiframe is 12 frames long. Frame 6 carries A and frame 12 carries B in each channel's LSB.
- R4: With `mode`=1, or the alias `mode`=3 (16-state extended superframe), the multiframe is 24 frames long. Frames 6, 12, 18 and 24 carry A, B, C and D.
- R5: With `mode`=2 (4-state extended superframe), frames 6 and 18 carry A, and frames 12 and 24 carry B.
- R6: The per-channel source code is `src_sel[2c+1:2c]`: 0 or 3 selects PCM (the LSB is not altered), 1 selects the register nibble and 2 selects the serial bus.
- R7: The register nibble of channel c is `reg_sig[4c+3:4c]`, with A at bit 4c, B at 4c+1, C at 4c+2 and D at 4c+3.
- R8: On `sig_bus`, the first four bits of channel c's timeslot carry A, B, C and D in that order. In modes 0 and 2 only A and B are captured. Bits at any other position are ignored.
- R9: Captured bus bits take effect at the next `msync`. The bits used during a multiframe are those last captured before that multiframe's `msync`.
- R10: `msync` sets the frame number to 1, and `fsync` advances it with wrap. Until the first `msync` no bit is altered.
- R11: While reset is asserted, `ser_out` is 0 and the bus holding and active registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial PCM in |
| fsync | input | 1 | High on the framing bit of each frame |
| msync | input | 1 | High on the framing bit of frame 1 |
| sig_bus | input | 1 | Serial signaling bus |
| mode | input | 2 | Multiframe format (0 SF, 1/3 ESF 16-state, 2 ESF 4-state) |
| src_sel | input | 48 | Two-bit source code per channel |
| reg_sig | input | 96 | Four-bit signaling nibble per channel |
| ser_out | output | 1 | Serial PCM out, one clock later |

## Verification
Every output bit is due one rising edge after its input bit. The bench drives each bit on a falling edge and compares `ser_out` at the next falling edge against the value it computed for the bit driven one step earlier. Bus signaling is due one multiframe after capture. The bench keeps its own model of the captured and active nibbles, and it changes the bus data halfway through each multiframe, so a value that took effect early or that mixed two captures shows up as a miscompare. Mode, source and register settings change only on the falling edge that drives the multiframe's first framing bit, so each multiframe is checked against a single configuration.

// File: rtl/t1rb_pkg.sv
package t1rb_pkg;

  typedef enum logic [1:0] {
    FMT_SF        = 2'd0,
    FMT_ESF16     = 2'd1,
    FMT_ESF4      = 2'd2,
    FMT_ESF16_ALT = 2'd3
  } rb_fmt_e;

  typedef enum logic [1:0] {
    SRC_PCM     = 2'd0,
    SRC_REG     = 2'd1,
    SRC_BUS     = 2'd2,
    SRC_PCM_ALT = 2'd3
  } rb_src_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] idx;
  } sig_slot_t;

  // Signaling letter carried by a frame number for a given format.
  function automatic sig_slot_t frame_slot(input logic [7:0] frame, input rb_fmt_e fmt);
    sig_slot_t s;
    s = '0;
    case (frame)
      8'd6: begin
        s.hit = 1'b1;
        s.idx = 2'd0;
      end
      8'd12: begin
        s.hit = 1'b1;
        s.idx = 2'd1;
      end
      8'd18: begin
        s.hit = (fmt != FMT_SF);
        s.idx = (fmt == FMT_ESF4) ? 2'd0 : 2'd2;
      end
      8'd24: begin
        s.hit = (fmt != FMT_SF);
        s.idx = (fmt == FMT_ESF4) ? 2'd1 : 2'd3;
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/t1rb_rst_sync.sv
module t1rb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_r <= 2'b00;
    end else begin
      sync_r <= {sync_r[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_r[1];

endmodule

// File: rtl/t1rb_timing.sv
module t1rb_timing #(
  parameter  int N_CH        = 24,
  parameter  int BITS_PER_CH = 8,
  parameter  int FRAMES_ESF  = 24,
  parameter  int FRAMES_SF   = 12,
  localparam int FRAME_BITS  = N_CH * BITS_PER_CH + 1,
  localparam int POS_W       = $clog2(FRAME_BITS),
  localparam int FR_W        = $clog2(FRAMES_ESF + 1),
  localparam int CH_W        = $clog2(N_CH),
  localparam int BIC_W       = $clog2(BITS_PER_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             msync,
  input  logic             is_sf,
  output logic [FR_W-1:0]  frame_q,
  output logic [FR_W-1:0]  cur_frame,
  output logic             slot_valid,
  output logic [CH_W-1:0]  cur_ch,
  output logic [BIC_W-1:0] cur_bic
);

  logic [POS_W-1:0] pos_r, pos_n, slot_off, quot, rem;
  logic [FR_W-1:0]  frame_r, frame_n, frame_last;
  logic             frame_mark;

  // Position and frame number of the bit presented this cycle.
  always_comb begin
    frame_mark = fsync | msync;
    frame_last = is_sf ? FR_W'(FRAMES_SF) : FR_W'(FRAMES_ESF);

    if (frame_mark) begin
      pos_n = '0;
    end else if (pos_r == POS_W'(FRAME_BITS - 1)) begin
      pos_n = '0;
    end else begin
      pos_n = pos_r + 1'b1;
    end

    frame_n = frame_r;
    if (msync) begin
      frame_n = FR_W'(1);
    end else if (fsync && (frame_r != '0)) begin
      frame_n = (frame_r >= frame_last) ? FR_W'(1) : frame_r + 1'b1;
    end

    slot_valid = (pos_n != '0);
    slot_off   = pos_n - 1'b1;
    quot       = slot_off / POS_W'(BITS_PER_CH);
    rem        = slot_off % POS_W'(BITS_PER_CH);
    cur_ch     = CH_W'(quot);
    cur_bic    = BIC_W'(rem);
    cur_frame  = frame_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_r   <= '0;
      frame_r <= '0;
    end else begin
      pos_r   <= pos_n;
      frame_r <= frame_n;
    end
  end

  assign frame_q = frame_r;

endmodule

// File: rtl/t1rb_bus_cap.sv
module t1rb_bus_cap #(
  parameter  int N_CH        = 24,
  parameter  int BITS_PER_CH = 8,
  parameter  int SIG_W       = 4,
  localparam int CH_W        = $clog2(N_CH),
  localparam int BIC_W       = $clog2(BITS_PER_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sig_bus,
  input  logic                   slot_valid,
  input  logic [CH_W-1:0]        cur_ch,
  input  logic [BIC_W-1:0]       cur_bic,
  input  logic                   ab_only,
  input  logic                   msync,
  output logic [N_CH*SIG_W-1:0]  bus_act
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic             hit;
    logic [SIG_W-1:0] pend_r, pend_n, act_r, act_n;

    always_comb begin
      hit    = slot_valid && (cur_ch == CH_W'(c));
      pend_n = pend_r;
      for (int k = 0; k < SIG_W; k++) begin
        if (hit && (cur_bic == BIC_W'(k)) && (!ab_only || (k < 2))) begin
          pend_n[k] = sig_bus;
        end
      end
      act_n = msync ? pend_r : act_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_r <= '0;
        act_r  <= '0;
      end else begin
        pend_r <= pend_n;
        act_r  <= act_n;
      end
    end

    assign bus_act[c*SIG_W +: SIG_W] = act_r;
  end

endmodule

// File: rtl/t1rb_insert.sv
module t1rb_insert
  import t1rb_pkg::*;
#(
  parameter  int N_CH        = 24,
  parameter  int BITS_PER_CH = 8,
  parameter  int SIG_W       = 4,
  parameter  int FR_W        = 5,
  localparam int CH_W        = $clog2(N_CH),
  localparam int BIC_W       = $clog2(BITS_PER_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_in,
  input  logic                  slot_valid,
  input  logic [CH_W-1:0]       cur_ch,
  input  logic [BIC_W-1:0]      cur_bic,
  input  logic [FR_W-1:0]       cur_frame,
  input  logic [1:0]            fmt,
  input  logic [2*N_CH-1:0]     src_sel,
  input  logic [SIG_W*N_CH-1:0] reg_sig,
  input  logic [SIG_W*N_CH-1:0] bus_act,
  output logic                  ser_out
);

  sig_slot_t        slot;
  rb_src_e          ch_src;
  logic [SIG_W-1:0] reg_bits, bus_bits;
  logic             rob, sig_bit, out_n, out_r;

  always_comb begin
    slot     = frame_slot(8'(cur_frame), rb_fmt_e'(fmt));
    rob      = slot_valid && (cur_bic == BIC_W'(BITS_PER_CH - 1)) && slot.hit;
    ch_src   = SRC_PCM;
    reg_bits = '0;
    bus_bits = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (cur_ch == CH_W'(c)) begin
        ch_src   = rb_src_e'(src_sel[2*c +: 2]);
        reg_bits = reg_sig[SIG_W*c +: SIG_W];
        bus_bits = bus_act[SIG_W*c +: SIG_W];
      end
    end
    case (ch_src)
      SRC_REG: sig_bit = reg_bits[slot.idx];
      SRC_BUS: sig_bit = bus_bits[slot.idx];
      default: sig_bit = ser_in;
    endcase
    out_n = rob ? sig_bit : ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r <= 1'b0;
    end else begin
      out_r <= out_n;
    end
  end

  assign ser_out = out_r;

endmodule

// File: rtl/t1_rbs_inserter.sv
module t1_rbs_inserter
  import t1rb_pkg::*;
#(
  parameter int N_CH        = 24,
  parameter int BITS_PER_CH = 8,
  parameter int SIG_W       = 4,
  parameter int FRAMES_ESF  = 24,
  parameter int FRAMES_SF   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_in,
  input  logic                  fsync,
  input  logic                  msync,
  input  logic                  sig_bus,
  input  logic [1:0]            mode,
  input  logic [2*N_CH-1:0]     src_sel,
  input  logic [SIG_W*N_CH-1:0] reg_sig,
  output logic                  ser_out
);

  localparam int FR_W  = $clog2(FRAMES_ESF + 1);
  localparam int CH_W  = $clog2(N_CH);
  localparam int BIC_W = $clog2(BITS_PER_CH);

  logic                  rst_sync_n;
  logic                  is_sf, ab_only;
  logic [FR_W-1:0]       frame_q, cur_frame;
  logic                  slot_valid;
  logic [CH_W-1:0]       cur_ch;
  logic [BIC_W-1:0]      cur_bic;
  logic [SIG_W*N_CH-1:0] bus_act;

  always_comb begin
    is_sf   = (rb_fmt_e'(mode) == FMT_SF);
    ab_only = is_sf || (rb_fmt_e'(mode) == FMT_ESF4);
  end

  t1rb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  t1rb_timing #(
    .N_CH        (N_CH),
    .BITS_PER_CH (BITS_PER_CH),
    .FRAMES_ESF  (FRAMES_ESF),
    .FRAMES_SF   (FRAMES_SF)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fsync      (fsync),
    .msync      (msync),
    .is_sf      (is_sf),
    .frame_q    (frame_q),
    .cur_frame  (cur_frame),
    .slot_valid (slot_valid),
    .cur_ch     (cur_ch),
    .cur_bic    (cur_bic)
  );

  t1rb_bus_cap #(
    .N_CH        (N_CH),
    .BITS_PER_CH (BITS_PER_CH),
    .SIG_W       (SIG_W)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sig_bus    (sig_bus),
    .slot_valid (slot_valid),
    .cur_ch     (cur_ch),
    .cur_bic    (cur_bic),
    .ab_only    (ab_only),
    .msync      (msync),
    .bus_act    (bus_act)
  );

  t1rb_insert #(
    .N_CH        (N_CH),
    .BITS_PER_CH (BITS_PER_CH),
    .SIG_W       (SIG_W),
    .FR_W        (FR_W)
  ) u_ins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ser_in     (ser_in),
    .slot_valid (slot_valid),
    .cur_ch     (cur_ch),
    .cur_bic    (cur_bic),
    .cur_frame  (cur_frame),
    .fmt        (mode),
    .src_sel    (src_sel),
    .reg_sig    (reg_sig),
    .bus_act    (bus_act),
    .ser_out    (ser_out)
  );

endmodule

// File: rtl/t1rb_checker.sv
module t1rb_checker #(
  parameter  int N_CH        = 24,
  parameter  int BITS_PER_CH = 8,
  parameter  int SIG_W       = 4,
  parameter  int FRAMES_ESF  = 24,
  parameter  int FRAMES_SF   = 12,
  localparam int FR_W        = $clog2(FRAMES_ESF + 1),
  localparam int CH_W        = $clog2(N_CH),
  localparam int BIC_W       = $clog2(BITS_PER_CH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fsync,
  input logic                  msync,
  input logic                  is_sf,
  input logic                  ser_in,
  input logic                  ser_out,
  input logic [FR_W-1:0]       frame_q,
  input logic                  slot_valid,
  input logic [CH_W-1:0]       cur_ch,
  input logic [BIC_W-1:0]      cur_bic,
  input logic [2*N_CH-1:0]     src_sel,
  input logic [SIG_W*N_CH-1:0] bus_act
);

  logic pcm_here;

  always_comb begin
    pcm_here = 1'b0;
    for (int c = 0; c < N_CH; c++) begin
      if (slot_valid && (cur_ch == CH_W'(c)) &&
          ((src_sel[2*c +: 2] == 2'd0) || (src_sel[2*c +: 2] == 2'd3))) begin
        pcm_here = 1'b1;
      end
    end
  end

  AST_NONLSB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_valid || (cur_bic != BIC_W'(BITS_PER_CH - 1))) |=> (ser_out == $past(ser_in))); // R1

  AST_FRAMING_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync || msync) ##1 !(fsync || msync) |-> (slot_valid && (cur_ch == '0) && (cur_bic == '0))); // R2

  AST_SF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sf && fsync && !msync && (frame_q == FR_W'(FRAMES_SF))) |=> (frame_q == FR_W'(1))); // R3

  AST_PCM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_here |=> (ser_out == $past(ser_in))); // R6

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !msync |=> $stable(bus_act)); // R9

  AST_MSYNC_FRAME1: assert property (@(posedge clk) disable iff (!rst_n)
    msync |=> (frame_q == FR_W'(1))); // R10

  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= FR_W'(FRAMES_ESF)); // R10

endmodule

bind t1_rbs_inserter t1rb_checker #(
  .N_CH        (N_CH),
  .BITS_PER_CH (BITS_PER_CH),
  .SIG_W       (SIG_W),
  .FRAMES_ESF  (FRAMES_ESF),
  .FRAMES_SF   (FRAMES_SF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .fsync      (fsync),
  .msync      (msync),
  .is_sf      (is_sf),
  .ser_in     (ser_in),
  .ser_out    (ser_out),
  .frame_q    (frame_q),
  .slot_valid (slot_valid),
  .cur_ch     (cur_ch),
  .cur_bic    (cur_bic),
  .src_sel    (src_sel),
  .bus_act    (bus_act)
);

// File: tb/t1_rbs_inserter_tb.sv
module t1_rbs_inserter_tb;

  localparam int N_CH  = 24;
  localparam int BPC   = 8;
  localparam int SIG_W = 4;
  localparam int FB    = N_CH * BPC + 1;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  ser_in, fsync, msync, sig_bus;
  logic [1:0]            mode;
  logic [2*N_CH-1:0]     src_sel;
  logic [SIG_W*N_CH-1:0] reg_sig;
  logic                  ser_out;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  logic  exp_q;
  bit    have_exp = 1'b0;
  string exp_tag;
  logic [3:0] bpend [N_CH];
  logic [3:0] bact  [N_CH];

  logic [1:0]            nxt_mode;
  logic [2*N_CH-1:0]     nxt_src;
  logic [SIG_W*N_CH-1:0] nxt_reg;
  bit                    apply_cfg = 1'b0;

  always #4 clk = ~clk;

  t1_rbs_inserter u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .fsync   (fsync),
    .msync   (msync),
    .sig_bus (sig_bus),
    .mode    (mode),
    .src_sel (src_sel),
    .reg_sig (reg_sig),
    .ser_out (ser_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ser_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one bit on a falling edge; check the bit driven one step earlier.
  task automatic push(input logic d, input logic fs, input logic ms, input logic b,
                      input logic e, input string tag);
    @(negedge clk);
    if (have_exp) check(ser_out, exp_q, exp_tag);
    ser_in  = d;
    fsync   = fs;
    msync   = ms;
    sig_bus = b;
    if (apply_cfg) begin
      mode      = nxt_mode;
      src_sel   = nxt_src;
      reg_sig   = nxt_reg;
      apply_cfg = 1'b0;
    end
    exp_q    = e;
    exp_tag  = tag;
    have_exp = 1'b1;
  endtask

  function automatic logic pcm_bit(input int m, input int f, input int pos);
    return (((pos * 13 + f * 7 + m * 5) % 7) < 3) ? 1'b1 : 1'b0;
  endfunction

  function automatic logic [3:0] bus_word(input int ch, input int m, input bit late);
    return late ? 4'((ch * 11 + m * 3 + 6) & 15) : 4'((ch * 7 + m * 5 + 1) & 15);
  endfunction

  function automatic logic reg_bit(input int ch, input int k, input int rot);
    return (((ch * 3 + k + rot) % 3) == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic set_cfg(input logic [1:0] md, input int rot);
    nxt_mode = md;
    for (int c = 0; c < N_CH; c++) begin
      nxt_src[2*c +: 2] = 2'((c + rot) % 4);
      for (int k = 0; k < SIG_W; k++) nxt_reg[SIG_W*c + k] = reg_bit(c, k, rot);
    end
    apply_cfg = 1'b1;
  endtask

  task automatic run_frames(input int m, input logic [1:0] md, input int rot,
                            input int nframes, input bit aligned);
    int per_mf = (md == 2'd0) ? 12 : 24;
    bit esf16  = (md == 2'd1) || (md == 2'd3);
    for (int f = 1; f <= nframes; f++) begin
      for (int pos = 0; pos < FB; pos++) begin
        int         ch  = (pos > 0) ? (pos - 1) / BPC : 0;
        int         bic = (pos > 0) ? (pos - 1) % BPC : 0;
        logic       d   = pcm_bit(m, f, pos);
        bit         ms  = aligned && (pos == 0) && (f == 1);
        logic       b;
        logic       e;
        logic [3:0] w;
        string      tag;
        int         idx;
        int         src;
        bit         hit;
        if (ms) for (int c = 0; c < N_CH; c++) bact[c] = bpend[c];
        w = bus_word(ch, m, f > per_mf / 2);
        if (pos > 0 && bic < 4) b = w[bic];
        else                    b = pcm_bit(m + 3, f, pos + 1);
        if (pos > 0 && bic < 4 && (bic < 2 || esf16)) bpend[ch][bic] = b;
        hit = aligned && ((f % 6) == 0);
        idx = f / 6 - 1;
        if (md == 2'd2) idx = idx % 2;
        e   = d;
        tag = aligned ? "R1 non-signaling bit passes" : "R10 no insertion before first multiframe sync";
        if (pos == 0) tag = "R2 framing bit passes";
        if (hit && pos > 0 && bic == BPC - 1) begin
          src = (ch + rot) % 4;
          if (src == 1) begin
            e   = reg_bit(ch, idx, rot);
            tag = (md == 2'd0) ? "R3 R7 register A/B" : (md == 2'd2) ? "R5 R7 register 4-state" : "R4 R7 register ABCD";
          end else if (src == 2) begin
            e   = bact[ch][idx];
            tag = (md == 2'd0) ? "R3 R8 R9 bus A/B" : (md == 2'd2) ? "R5 R8 R9 bus 4-state" : "R4 R8 R9 bus ABCD";
          end else begin
            tag = "R6 PCM source leaves LSB";
          end
        end
        push(d, pos == 0, ms, b, e, tag);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int m = 0;
    for (int c = 0; c < N_CH; c++) begin
      bpend[c] = '0;
      bact[c]  = '0;
    end
    rst_n   = 1'b0;
    ser_in  = 1'b1;
    fsync   = 1'b0;
    msync   = 1'b0;
    sig_bus = 1'b0;
    mode    = 2'd1;
    src_sel = '0;
    reg_sig = '1;
    repeat (4) @(negedge clk);
    check(ser_out, 1'b0, "R11 output low in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    set_cfg(2'd1, 0);
    run_frames(m, 2'd1, 0, 7, 1'b0);
    m++;
    for (int md = 0; md < 4; md++) begin
      for (int rot = 0; rot < 2; rot++) begin
        for (int rep = 0; rep < 2; rep++) begin
          set_cfg(2'(md), rot);
          run_frames(m, 2'(md), rot, (md == 0) ? 12 : 24, 1'b1);
          m++;
        end
      end
    end
    @(negedge clk);
    check(ser_out, exp_q, exp_tag);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule